// File: doc/BRIEF.md
# UART Interrupt Prioritizer and Identifier

This block collects the interrupt conditions of a 16550-style serial port into one registered interrupt line and a 4-bit identification code. The conditions are a receive line-status error event, a receive FIFO fill level measured against a trigger level, a character-timeout tick, the transmit-empty status and modem-line change events. Each condition is masked by its own enable bit. When several conditions are pending at once, a fixed priority picks the one that is reported. The read and write strobes of the neighbouring registers clear the pending conditions.

The block also owns the transmit-empty status bit. A write of a character into the transmit FIFO clears this bit at once. The bit stays low for one character time after the write, even when the FIFO is already empty again. A down-counter, clocked by the bit-rate strobe, measures this hold-off. Its load value is one start bit plus the number of data bits set by the character-length code.

Top module: `uart_irq_arbiter`

## Requirements
- R1: After reset, `irq_o` is 0, `irq_id_o` is 0001 (nothing pending) and `thre_o` is 1.
- R2: A one-cycle pulse on `ls_err_i` makes the line-status source pending. With enable bit 2 set, it is reported as code 0110. A pulse on `rd_lsr_i` clears it.
- R3: The data-available source is pending while `rx_count_i` is non-zero and `rx_count_i >= rx_trig_i`. With enable bit 0 set, it is reported as code 0100. It clears as soon as the count drops below the trigger level.
- R4: A `tmo_tick_i` pulse makes the timeout source pending only if `rx_count_i` is non-zero. The tick is ignored when the count is zero. The source is reported as code 1100 under enable bit 0, and a pulse on `rd_rbr_i` clears it.
- R5: The transmit-empty source is reported as code 0010 under enable bit 1. It becomes pending when `thre_o` rises while the bit is enabled, or when the bit is enabled while `thre_o` is high. A pulse on `rd_iir_i` clears it only if 0010 is the code being reported at that moment. A write on `wr_thr_i` also clears it.
- R6: A write on `wr_thr_i` forces `thre_o` to 0 on the next cycle. `thre_o` cannot return to 1 until `6 + len_code_i` pulses of `bit_tick_i` have followed the write, with `tx_empty_i` high.
- R7: Any bit of `ms_delta_i` makes the modem source pending. With enable bit 3 set, it is reported as code 0000. A pulse on `rd_msr_i` clears all change flags.
- R8: When several sources are pending, the reported code follows this order: line status first, then data available, then timeout, then transmit empty, then modem.
- R9: Clearing an enable bit removes its source from arbitration on the next cycle. When all enable bits are 0, `irq_o` is 0.
- R10: `iir_rdata_o` always equals 1100 in its upper four bits, followed by the current 4-bit identification code.
- R11: Once `thre_o` is 1, it stays 1 until a write on `wr_thr_i`. A line-status read or `tx_empty_i` going low does not clear it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_i | input | 4 | Enables: bit0 receive data/timeout, bit1 transmit empty, bit2 line status, bit3 modem |
| len_code_i | input | 2 | Character length code, 0..3 for 5..8 data bits |
| ls_err_i | input | 1 | Receive line-status error event (pulse) |
| rx_count_i | input | CNT_W | Receive FIFO fill count |
| rx_trig_i | input | CNT_W | Receive FIFO trigger level |
| tmo_tick_i | input | 1 | Character-timeout event (pulse) |
| tx_empty_i | input | 1 | Transmit FIFO and shifter empty |
| bit_tick_i | input | 1 | One pulse per serial bit time |
| ms_delta_i | input | 4 | Modem-line change events |
| rd_iir_i | input | 1 | Identification register read strobe |
| rd_lsr_i | input | 1 | Line-status register read strobe |
| rd_msr_i | input | 1 | Modem-status register read strobe |
| rd_rbr_i | input | 1 | Receive buffer read strobe |
| wr_thr_i | input | 1 | Transmit holding register write strobe |
| irq_o | output | 1 | Registered interrupt request |
| irq_id_o | output | 4 | Registered identification code |
| iir_rdata_o | output | 8 | Identification register read value |
| thre_o | output | 1 | Transmit-empty status bit |

## Verification
The hardest case to reach from the ports is an identification read that must leave a pending transmit-empty interrupt in place. This happens only when a higher-priority source hides that interrupt at the moment of the read. The stimulus first enables the transmit-empty source. It then raises a line-status error on top of it, reads the identification register while code 0110 is showing, clears the line status, and expects 0010 to come back. A second hard case is the edge of the hold-off window. The bench counts bit ticks one short of the load value and checks that the status bit is still low. It then adds the last tick and checks that the bit sets and raises a new transmit-empty interrupt.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  // Identification codes reported by the arbiter
  localparam logic [3:0] ID_NONE = 4'b0001;
  localparam logic [3:0] ID_RLS  = 4'b0110;
  localparam logic [3:0] ID_RDA  = 4'b0100;
  localparam logic [3:0] ID_TMO  = 4'b1100;
  localparam logic [3:0] ID_THRE = 4'b0010;
  localparam logic [3:0] ID_MS   = 4'b0000;

  // Enable bit positions
  localparam int IE_RX   = 0;
  localparam int IE_THRE = 1;
  localparam int IE_LS   = 2;
  localparam int IE_MS   = 3;

  localparam logic [3:0] IIR_UPPER = 4'b1100;

  // Start bit plus data bits (5..8) of one character, stop bit excluded
  function automatic logic [3:0] hold_len(input logic [1:0] len_code);
    return 4'd6 + {2'b00, len_code};
  endfunction

  // Fixed-priority pick over the masked sources
  function automatic logic [3:0] pick_id(input logic rls, input logic rda,
                                         input logic tmo, input logic thre,
                                         input logic ms);
    if (rls)       return ID_RLS;
    else if (rda)  return ID_RDA;
    else if (tmo)  return ID_TMO;
    else if (thre) return ID_THRE;
    else if (ms)   return ID_MS;
    else           return ID_NONE;
  endfunction

endpackage

// File: rtl/uart_irq_thre_gate.sv
module uart_irq_thre_gate
  import uart_irq_pkg::*;
#(
  parameter int BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_thr,
  input  logic             bit_tick,
  input  logic             tx_empty,
  input  logic [1:0]       len_code,
  output logic             thre_st,
  output logic             thre_rise,
  output logic [BLK_W-1:0] blk_cnt
);

  logic thre_d;
  logic blk_done;

  assign blk_done = (blk_cnt == '0);

  // Hold-off counter: loaded on a write, counts bit times down
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_cnt <= '0;
    end else if (wr_thr) begin
      blk_cnt <= BLK_W'(hold_len(len_code));
    end else if (bit_tick && !blk_done) begin
      blk_cnt <= blk_cnt - 1'b1;
    end
  end

  // Status bit: cleared only by a write, set once the window has elapsed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_st <= 1'b1;
      thre_d  <= 1'b1;
    end else begin
      thre_d <= thre_st;
      if (wr_thr) begin
        thre_st <= 1'b0;
      end else if (tx_empty && blk_done) begin
        thre_st <= 1'b1;
      end
    end
  end

  assign thre_rise = thre_st & ~thre_d;

endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int MS_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ls_err,
  input  logic [CNT_W-1:0] rx_count,
  input  logic [CNT_W-1:0] rx_trig,
  input  logic             tmo_tick,
  input  logic [MS_W-1:0]  ms_delta,
  input  logic             rd_lsr,
  input  logic             rd_rbr,
  input  logic             rd_msr,
  input  logic             rd_iir,
  input  logic             wr_thr,
  input  logic             thre_st,
  input  logic             thre_rise,
  input  logic             ie_thre,
  input  logic [3:0]       cur_id,
  output logic             rls_p,
  output logic             rda_p,
  output logic             tmo_p,
  output logic             thre_p,
  output logic             ms_p,
  output logic [MS_W-1:0]  ms_flags
);

  logic rx_nonempty;
  logic tmo_q;
  logic ie_thre_d;
  logic thre_set;
  logic thre_clr;

  assign rx_nonempty = (rx_count != '0);

  // Line status: an error event sets, a status read clears
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rls_p <= 1'b0;
    else if (ls_err) rls_p <= 1'b1;
    else if (rd_lsr) rls_p <= 1'b0;
  end

  // Data available is a level compare
  assign rda_p = rx_nonempty && (rx_count >= rx_trig);

  // Timeout: accepted only with data present, cleared by a buffer read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          tmo_q <= 1'b0;
    else if (tmo_tick && rx_nonempty)    tmo_q <= 1'b1;
    else if (rd_rbr)                     tmo_q <= 1'b0;
  end
  assign tmo_p = tmo_q && rx_nonempty;

  // Transmit empty: cleared by a read only when it is the reported code
  assign thre_set = thre_rise || (ie_thre && !ie_thre_d && thre_st);
  assign thre_clr = wr_thr || (rd_iir && (cur_id == ID_THRE)) || !thre_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thre_p    <= 1'b0;
      ie_thre_d <= 1'b0;
    end else begin
      ie_thre_d <= ie_thre;
      if (thre_set)      thre_p <= 1'b1;
      else if (thre_clr) thre_p <= 1'b0;
    end
  end

  // Modem change flags: sticky per line, cleared by a status read
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ms_flags <= '0;
    else        ms_flags <= (ms_flags & ~{MS_W{rd_msr}}) | ms_delta;
  end
  assign ms_p = |ms_flags;

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] ier,
  input  logic       rls_p,
  input  logic       rda_p,
  input  logic       tmo_p,
  input  logic       thre_p,
  input  logic       ms_p,
  output logic       irq_q,
  output logic [3:0] id_q
);

  logic m_rls, m_rda, m_tmo, m_thre, m_ms;

  assign m_rls  = rls_p  & ier[IE_LS];
  assign m_rda  = rda_p  & ier[IE_RX];
  assign m_tmo  = tmo_p  & ier[IE_RX];
  assign m_thre = thre_p & ier[IE_THRE];
  assign m_ms   = ms_p   & ier[IE_MS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      id_q  <= ID_NONE;
    end else begin
      irq_q <= m_rls | m_rda | m_tmo | m_thre | m_ms;
      id_q  <= pick_id(m_rls, m_rda, m_tmo, m_thre, m_ms);
    end
  end

endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int BLK_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ier_i,
  input  logic [1:0]       len_code_i,
  input  logic             ls_err_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic             tmo_tick_i,
  input  logic             tx_empty_i,
  input  logic             bit_tick_i,
  input  logic [3:0]       ms_delta_i,
  input  logic             rd_iir_i,
  input  logic             rd_lsr_i,
  input  logic             rd_msr_i,
  input  logic             rd_rbr_i,
  input  logic             wr_thr_i,
  output logic             irq_o,
  output logic [3:0]       irq_id_o,
  output logic [7:0]       iir_rdata_o,
  output logic             thre_o
);

  localparam int MS_W = 4;

  logic             thre_st;
  logic             thre_rise;
  logic [BLK_W-1:0] blk_cnt;
  logic             rls_p, rda_p, tmo_p, thre_p, ms_p;
  logic [MS_W-1:0]  ms_flags;

  uart_irq_thre_gate #(.BLK_W(BLK_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_thr   (wr_thr_i),
    .bit_tick (bit_tick_i),
    .tx_empty (tx_empty_i),
    .len_code (len_code_i),
    .thre_st  (thre_st),
    .thre_rise(thre_rise),
    .blk_cnt  (blk_cnt)
  );

  uart_irq_sources #(.CNT_W(CNT_W), .MS_W(MS_W)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .ls_err   (ls_err_i),
    .rx_count (rx_count_i),
    .rx_trig  (rx_trig_i),
    .tmo_tick (tmo_tick_i),
    .ms_delta (ms_delta_i),
    .rd_lsr   (rd_lsr_i),
    .rd_rbr   (rd_rbr_i),
    .rd_msr   (rd_msr_i),
    .rd_iir   (rd_iir_i),
    .wr_thr   (wr_thr_i),
    .thre_st  (thre_st),
    .thre_rise(thre_rise),
    .ie_thre  (ier_i[IE_THRE]),
    .cur_id   (irq_id_o),
    .rls_p    (rls_p),
    .rda_p    (rda_p),
    .tmo_p    (tmo_p),
    .thre_p   (thre_p),
    .ms_p     (ms_p),
    .ms_flags (ms_flags)
  );

  uart_irq_prio u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .ier   (ier_i),
    .rls_p (rls_p),
    .rda_p (rda_p),
    .tmo_p (tmo_p),
    .thre_p(thre_p),
    .ms_p  (ms_p),
    .irq_q (irq_o),
    .id_q  (irq_id_o)
  );

  assign thre_o      = thre_st;
  assign iir_rdata_o = {IIR_UPPER, irq_id_o};

endmodule

// File: rtl/uart_irq_arbiter_chk.sv
module uart_irq_arbiter_chk
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int BLK_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       ier,
  input logic [CNT_W-1:0] rx_count,
  input logic             wr_thr,
  input logic             rd_msr,
  input logic [3:0]       ms_delta,
  input logic             rls_p,
  input logic [3:0]       ms_flags,
  input logic [BLK_W-1:0] blk_cnt,
  input logic             irq,
  input logic [3:0]       irq_id,
  input logic             thre
);

  AST_RLS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (rls_p && ier[IE_LS]) |=> (irq_id == ID_RLS)); // R8

  AST_TMO_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_id == ID_TMO) |-> ($past(rx_count) != '0)); // R4

  AST_THRE_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_thr |=> !thre); // R6

  AST_THRE_HOLD_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(thre) |-> ($past(blk_cnt) == '0)); // R6

  AST_MS_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_msr && (ms_delta == 4'b0000)) |=> (ms_flags == 4'b0000)); // R7

  AST_MASK_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (ier == 4'b0000) |=> !irq); // R9

endmodule

bind uart_irq_arbiter uart_irq_arbiter_chk #(.CNT_W(CNT_W), .BLK_W(BLK_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ier     (ier_i),
  .rx_count(rx_count_i),
  .wr_thr  (wr_thr_i),
  .rd_msr  (rd_msr_i),
  .ms_delta(ms_delta_i),
  .rls_p   (rls_p),
  .ms_flags(ms_flags),
  .blk_cnt (blk_cnt),
  .irq     (irq_o),
  .irq_id  (irq_id_o),
  .thre    (thre_o)
);

// File: tb/tb_uart_irq_arbiter.sv
`timescale 1ns/1ps
module tb_uart_irq_arbiter;

  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [3:0]       ier = '0;
  logic [1:0]       len_code = '0;
  logic             ls_err = 1'b0;
  logic [CNT_W-1:0] rx_count = '0;
  logic [CNT_W-1:0] rx_trig = 5'd4;
  logic             tmo_tick = 1'b0;
  logic             tx_empty = 1'b1;
  logic             bit_tick = 1'b0;
  logic [3:0]       ms_delta = '0;
  logic             rd_iir = 1'b0, rd_lsr = 1'b0, rd_msr = 1'b0, rd_rbr = 1'b0, wr_thr = 1'b0;
  logic             irq;
  logic [3:0]       irq_id;
  logic [7:0]       iir_rdata;
  logic             thre;

  always #2 clk = ~clk;

  uart_irq_arbiter #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .ier_i(ier), .len_code_i(len_code),
    .ls_err_i(ls_err), .rx_count_i(rx_count), .rx_trig_i(rx_trig),
    .tmo_tick_i(tmo_tick), .tx_empty_i(tx_empty), .bit_tick_i(bit_tick),
    .ms_delta_i(ms_delta), .rd_iir_i(rd_iir), .rd_lsr_i(rd_lsr),
    .rd_msr_i(rd_msr), .rd_rbr_i(rd_rbr), .wr_thr_i(wr_thr),
    .irq_o(irq), .irq_id_o(irq_id), .iir_rdata_o(iir_rdata), .thre_o(thre)
  );

  typedef struct {
    logic       irq;
    logic [3:0] id;
    logic       thre;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // Strobe selectors
  localparam int S_LSERR = 0, S_TMO = 1, S_BIT = 2, S_IIR = 3, S_LSR = 4,
                 S_MSR = 5, S_RBR = 6, S_THR = 7;

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      S_LSERR: ls_err   = 1'b1;
      S_TMO:   tmo_tick = 1'b1;
      S_BIT:   bit_tick = 1'b1;
      S_IIR:   rd_iir   = 1'b1;
      S_LSR:   rd_lsr   = 1'b1;
      S_MSR:   rd_msr   = 1'b1;
      S_RBR:   rd_rbr   = 1'b1;
      default: wr_thr   = 1'b1;
    endcase
    @(negedge clk);
    {ls_err, tmo_tick, bit_tick, rd_iir, rd_lsr, rd_msr, rd_rbr, wr_thr} = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      strobe(S_BIT);
      @(negedge clk);
    end
  endtask

  // Driver side of the scoreboard: settle, then queue what must be seen
  task automatic expect_state(input logic e_irq, input logic [3:0] e_id,
                              input logic e_thre, input string tag);
    exp_t it;
    repeat (3) @(negedge clk);
    it.irq = e_irq; it.id = e_id; it.thre = e_thre; it.tag = tag;
    exp_q.push_back(it);
    repeat (2) @(negedge clk);
  endtask

  // Monitor side: pops and compares against the ports
  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        n_chk++;
        if (irq !== it.irq || irq_id !== it.id || thre !== it.thre ||
            iir_rdata !== {4'b1100, it.id}) begin
          n_bad++;
          $display("FAIL %s: irq=%b id=%b thre=%b iir=%h expected irq=%b id=%b thre=%b iir=%h",
                   it.tag, irq, irq_id, thre, iir_rdata, it.irq, it.id, it.thre,
                   {4'b1100, it.id});
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1, R10: reset state, identification read value C1
    expect_state(1'b0, 4'b0001, 1'b1, "R1 reset");

    // R3: data available at and below trigger level
    ier = 4'b0001;
    rx_count = 5'd4;
    expect_state(1'b1, 4'b0100, 1'b1, "R3 count at trigger");
    rx_count = 5'd3;
    expect_state(1'b0, 4'b0001, 1'b1, "R3 count below trigger");

    // R4: timeout with data, cleared by buffer read; ignored with empty FIFO
    rx_count = 5'd2;
    strobe(S_TMO);
    expect_state(1'b1, 4'b1100, 1'b1, "R4 timeout with data");
    strobe(S_RBR);
    expect_state(1'b0, 4'b0001, 1'b1, "R4 buffer read clears timeout");
    rx_count = 5'd0;
    strobe(S_TMO);
    rx_count = 5'd2;
    expect_state(1'b0, 4'b0001, 1'b1, "R4 tick on empty FIFO ignored");

    // R2, R8: line status over data available
    ier = 4'b0101;
    rx_count = 5'd4;
    strobe(S_LSERR);
    expect_state(1'b1, 4'b0110, 1'b1, "R2 R8 line status wins");
    strobe(S_LSR);
    expect_state(1'b1, 4'b0100, 1'b1, "R2 status read clears, R8 next level");
    rx_count = 5'd0;
    expect_state(1'b0, 4'b0001, 1'b1, "R3 drained");

    // R5: enable with status high raises transmit empty
    ier = 4'b0111;
    expect_state(1'b1, 4'b0010, 1'b1, "R5 enable while empty");
    strobe(S_LSERR);
    expect_state(1'b1, 4'b0110, 1'b1, "R8 line status hides transmit empty");
    strobe(S_IIR);
    strobe(S_LSR);
    expect_state(1'b1, 4'b0010, 1'b1, "R5 id read while hidden keeps it");
    strobe(S_IIR);
    expect_state(1'b0, 4'b0001, 1'b1, "R5 id read while reported clears");

    // R6, R11: hold-off window for 8 data bits = 9 bit times
    len_code = 2'd3;
    strobe(S_THR);
    expect_state(1'b0, 4'b0001, 1'b0, "R6 write clears status");
    strobe(S_LSR);
    ticks(8);
    expect_state(1'b0, 4'b0001, 1'b0, "R6 still held after 8 ticks");
    ticks(1);
    expect_state(1'b1, 4'b0010, 1'b1, "R6 sets after 9 ticks, R5 interrupt");

    // R11: status survives FIFO not empty and a line-status read
    tx_empty = 1'b0;
    strobe(S_LSR);
    expect_state(1'b1, 4'b0010, 1'b1, "R11 status sticky");
    strobe(S_IIR);
    expect_state(1'b0, 4'b0001, 1'b1, "R5 cleared before modem test");

    // R7, R10: modem change
    ier = 4'b1000;
    ms_delta = 4'b0100;
    @(negedge clk);
    ms_delta = 4'b0000;
    expect_state(1'b1, 4'b0000, 1'b1, "R7 modem change, R10 read value C0");
    strobe(S_MSR);
    expect_state(1'b0, 4'b0001, 1'b1, "R7 status read clears");

    // R9: masking removes a pending source, unmasking restores it
    ms_delta = 4'b0001;
    @(negedge clk);
    ms_delta = 4'b0000;
    ier = 4'b0000;
    expect_state(1'b0, 4'b0001, 1'b1, "R9 all enables off");
    ier = 4'b1000;
    expect_state(1'b1, 4'b0000, 1'b1, "R9 enable restored");
    strobe(S_MSR);
    ier = 4'b0000;

    // R6: 5 data bits = 6 bit times
    tx_empty = 1'b1;
    len_code = 2'd0;
    strobe(S_THR);
    ticks(5);
    expect_state(1'b0, 4'b0001, 1'b0, "R6 held after 5 ticks");
    ticks(1);
    expect_state(1'b0, 4'b0001, 1'b1, "R6 sets after 6 ticks");

    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule